// File: doc/BRIEF.md
# I2S Transmit Serializer

This block turns parallel audio words into a serial I2S data stream. Software or a DMA engine drops one word at a time into a single-entry holding register. At the start of every channel slot the serializer moves the held word into a shift register and sends it most significant bit first. The word-select line is low for the left channel and high for the right channel. The first data bit of a slot comes out one bit clock after the word-select change.

The block can run as clock master, producing the bit clock and word select from the system clock. It can also run as a slave, following an external bit clock and word select that it synchronises internally. Several configuration inputs set the behaviour:

- the sample length, including two compact modes that carry both channels in one word;
- a narrow 24-bit slot for 18, 20 and 24-bit samples;
- mono duplication of the left sample into the right slot;
- what is sent when no word is waiting: silence, or a repeat of the last sample.

A loopback select routes the serial output back onto the receive data line.

Top module: `i2s_tx_serializer`

## Requirements
- R1: After reset, tx_ready is 1, tx_underrun is 0, sd_o is 0, bclk_o is 0 and ws_o is 1.
- R2: The holding register has one entry. tx_ready is 1 exactly when it is empty. An accepted write drops tx_ready in the next cycle, and tx_ready rises again once the word is moved out at a slot start.
- R3: In master mode, bclk_o toggles every HALF_DIV clock cycles, and ws_o and sd_o change only when bclk_o falls. ws_o low marks the left slot. The first bit of a slot appears at the bclk_o falling edge one bit after the one at which ws_o changed, and the bit sent during the first bit after the change is the last bit of the previous slot.
- R4: Samples are sent MSB-first and left-aligned in the slot, with zero padding after them. The sample occupies the low bits of the written word and the higher bits are ignored. cfg_len encodes: 0 = 32 bits, 1 = 24, 2 = 20, 3 = 18, 4 = 16, 5 = 16 packed, 6 = 8, 7 = 8 packed.
- R5: A slot is 32 bits for lengths 0 to 3 with cfg_narrow = 0, 24 bits for lengths 1 to 3 with cfg_narrow = 1, 16 bits for lengths 4 and 5, and 8 bits for lengths 6 and 7.
- R6: With cfg_mono = 1 (and an unpacked length), each word fills the left slot and the same sample is sent again in the right slot, without consuming a second word.
- R7: In the packed lengths, one word serves a whole frame. For length 5 the left sample is bits 15:0 and the right sample is bits 31:16. For length 7 the left sample is bits 7:0 and the right sample is bits 15:8.
- R8: If the holding register is empty at a slot start while tx_en = 1, the slot is an underrun. With cfg_repeat = 0 the slot carries all zeros, and tx_underrun rises.
- R9: With cfg_repeat = 1, an underrun slot repeats the sample most recently sent.
- R10: tx_underrun stays set until ur_clr is pulsed. A new underrun in the same cycle as ur_clr wins.
- R11: With cfg_loop = 1, rx_sd_o follows sd_o. With cfg_loop = 0, rx_sd_o follows rx_sd_i.
- R12: In slave mode (cfg_master = 0), slots follow ext_bclk falling edges and ext_ws with the same one-bit delay and bit order as in master mode. bclk_o stays 0 and ws_o stays 1.
- R13: While tx_en = 0, a held word is not consumed and no underrun is raised. In master mode bclk_o stays 0. Once tx_en rises, the first word goes into the first left slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmitter enable |
| cfg_master | input | 1 | 1 = generate bit clock and word select, 0 = follow external ones |
| cfg_len | input | 3 | Sample length code |
| cfg_narrow | input | 1 | 24-bit slot for 18/20/24-bit samples |
| cfg_mono | input | 1 | Duplicate left sample into right slot |
| cfg_repeat | input | 1 | Underrun fill: 0 = zeros, 1 = last sample |
| cfg_loop | input | 1 | Route serial output onto rx_sd_o |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_data | input | 32 | Word to transmit |
| tx_ready | output | 1 | Holding register empty |
| ur_clr | input | 1 | Clear the underrun flag |
| tx_underrun | output | 1 | Sticky underrun flag |
| ext_bclk | input | 1 | External bit clock (slave) |
| ext_ws | input | 1 | External word select (slave) |
| bclk_o | output | 1 | Generated bit clock (master) |
| ws_o | output | 1 | Generated word select (master) |
| sd_o | output | 1 | Serial data out |
| rx_sd_i | input | 1 | Serial data from the pin toward the receiver |
| rx_sd_o | output | 1 | Serial data to the receiver, after the loopback select |

## Verification
The bench decodes the stream the way an I2S receiver would. Any design that drops the one-bit delay after the word-select change, or that loads at the wrong edge, shows up as a word shifted by one bit with its LSB landing in the next slot. Short slots (24, 16 and 8 bits) and packed or mono frames catch a design that counts slot length wrongly or consumes a second word when it should reuse the first. The bench also runs the holding register dry: one run expects a zero slot and one expects a repeated sample, and a design that mixes up the two policies or fails to keep the flag set until it is cleared is caught there. Slave mode and the tx_en-low hold catch designs that keep running their own clock, or that drain the held word while disabled.

// File: rtl/i2stx_pkg.sv
package i2stx_pkg;

    localparam int WORD_W = 32;
    localparam int SLOT_W = 6;

    typedef enum logic [2:0] {
        LEN_32  = 3'd0,
        LEN_24  = 3'd1,
        LEN_20  = 3'd2,
        LEN_18  = 3'd3,
        LEN_16  = 3'd4,
        LEN_16P = 3'd5,
        LEN_8   = 3'd6,
        LEN_8P  = 3'd7
    } len_e;

    // number of bit clocks in one channel slot
    function automatic logic [SLOT_W-1:0] slot_bits(len_e l, logic narrow);
        case (l)
            LEN_24, LEN_20, LEN_18: slot_bits = narrow ? 6'd24 : 6'd32;
            LEN_16, LEN_16P:        slot_bits = 6'd16;
            LEN_8, LEN_8P:          slot_bits = 6'd8;
            default:                slot_bits = 6'd32;
        endcase
    endfunction

    // low-part sample moved to the top of the shift word
    function automatic logic [WORD_W-1:0] align_lo(logic [WORD_W-1:0] w, len_e l);
        case (l)
            LEN_24:          align_lo = {w[23:0], 8'b0};
            LEN_20:          align_lo = {w[19:0], 12'b0};
            LEN_18:          align_lo = {w[17:0], 14'b0};
            LEN_16, LEN_16P: align_lo = {w[15:0], 16'b0};
            LEN_8, LEN_8P:   align_lo = {w[7:0], 24'b0};
            default:         align_lo = w;
        endcase
    endfunction

    // second sample of a packed word
    function automatic logic [WORD_W-1:0] align_hi(logic [WORD_W-1:0] w, len_e l);
        if (l == LEN_8P) align_hi = {w[15:8], 24'b0};
        else             align_hi = {w[31:16], 16'b0};
    endfunction

endpackage

// File: rtl/i2stx_timing.sv
module i2stx_timing
    import i2stx_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              master,
    input  logic [SLOT_W-1:0] slot,
    input  logic              ext_bclk,
    input  logic              ext_ws,
    output logic              tick,
    output logic              ws_cur,
    output logic              bclk_o,
    output logic              ws_o
);
    localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    typedef struct packed {
        logic [DW-1:0]     div;
        logic              bclk;
        logic [SLOT_W-1:0] bit_cnt;
        logic              ws;
        logic [2:0]        bsy;
        logic [1:0]        wsy;
    } tim_t;

    tim_t tim_d, tim_q;

    always_comb begin
        tim_d  = tim_q;
        tick   = 1'b0;
        ws_cur = tim_q.ws;
        tim_d.bsy = {tim_q.bsy[1:0], ext_bclk};
        tim_d.wsy = {tim_q.wsy[0], ext_ws};
        if (!master || !enable) begin
            tim_d.div     = '0;
            tim_d.bclk    = 1'b0;
            tim_d.bit_cnt = '0;
            tim_d.ws      = 1'b1;
            if (!master) begin
                tick   = tim_q.bsy[2] & ~tim_q.bsy[1];
                ws_cur = tim_q.wsy[1];
            end
        end else if (tim_q.div == DW'(HALF_DIV - 1)) begin
            tim_d.div  = '0;
            tim_d.bclk = ~tim_q.bclk;
            if (tim_q.bclk) begin
                tick = 1'b1;
                if (tim_q.bit_cnt == slot - 6'd1) begin
                    tim_d.bit_cnt = '0;
                    tim_d.ws      = ~tim_q.ws;
                end else begin
                    tim_d.bit_cnt = tim_q.bit_cnt + 6'd1;
                end
            end
            ws_cur = tim_d.ws;
        end else begin
            tim_d.div = tim_q.div + DW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tim_q     <= '0;
            tim_q.ws  <= 1'b1;
            tim_q.wsy <= 2'b11;
        end else begin
            tim_q <= tim_d;
        end
    end

    assign bclk_o = tim_q.bclk;
    assign ws_o   = tim_q.ws;

endmodule

// File: rtl/i2stx_holding.sv
module i2stx_holding
    import i2stx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [WORD_W-1:0] data
);
    typedef struct packed {
        logic              full;
        logic [WORD_W-1:0] data;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (take) hold_d.full = 1'b0;
        if (wr_valid && !hold_q.full) begin
            hold_d.full = 1'b1;
            hold_d.data = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign full = hold_q.full;
    assign data = hold_q.data;

endmodule

// File: rtl/i2s_tx_serializer.sv
module i2s_tx_serializer
    import i2stx_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tx_en,
    input  logic        cfg_master,
    input  logic [2:0]  cfg_len,
    input  logic        cfg_narrow,
    input  logic        cfg_mono,
    input  logic        cfg_repeat,
    input  logic        cfg_loop,
    input  logic        wr_valid,
    input  logic [31:0] wr_data,
    output logic        tx_ready,
    input  logic        ur_clr,
    output logic        tx_underrun,
    input  logic        ext_bclk,
    input  logic        ext_ws,
    output logic        bclk_o,
    output logic        ws_o,
    output logic        sd_o,
    input  logic        rx_sd_i,
    output logic        rx_sd_o
);
    typedef struct packed {
        logic [WORD_W-1:0] sh;
        logic [WORD_W-1:0] right;
        logic [WORD_W-1:0] last;
        logic              sd;
        logic              ws_last;
        logic              ur;
    } ser_t;

    ser_t ser_d, ser_q;

    len_e              len;
    logic [SLOT_W-1:0] slot;
    logic              tick, ws_cur, take, hold_full, packed_mode;
    logic [WORD_W-1:0] hold_data, fresh, fill;

    assign len         = len_e'(cfg_len);
    assign slot        = slot_bits(len, cfg_narrow);
    assign packed_mode = (len == LEN_16P) || (len == LEN_8P);

    i2stx_timing #(.HALF_DIV(HALF_DIV)) i_timing (
        .clk(clk), .rst_n(rst_n), .enable(tx_en), .master(cfg_master),
        .slot(slot), .ext_bclk(ext_bclk), .ext_ws(ext_ws),
        .tick(tick), .ws_cur(ws_cur), .bclk_o(bclk_o), .ws_o(ws_o)
    );

    i2stx_holding i_holding (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .take(take), .full(hold_full), .data(hold_data)
    );

    assign fill = cfg_repeat ? ser_q.last : '0;

    always_comb begin
        ser_d    = ser_q;
        take     = 1'b0;
        fresh    = '0;
        ser_d.ur = ur_clr ? 1'b0 : ser_q.ur;
        if (tick) begin
            // the edge that flips word select still carries the old slot's last bit
            ser_d.sd      = ser_q.sh[WORD_W-1];
            ser_d.sh      = {ser_q.sh[WORD_W-2:0], 1'b0};
            ser_d.ws_last = ws_cur;
            if (ws_cur != ser_q.ws_last) begin
                if (!tx_en) begin
                    fresh = '0;
                end else if (!ws_cur) begin
                    if (hold_full) begin
                        take        = 1'b1;
                        fresh       = align_lo(hold_data, len);
                        ser_d.right = packed_mode ? align_hi(hold_data, len) : fresh;
                    end else begin
                        fresh       = fill;
                        ser_d.right = fill;
                        ser_d.ur    = 1'b1;
                    end
                    ser_d.last = fresh;
                end else begin
                    if (packed_mode || cfg_mono) begin
                        fresh = ser_q.right;
                    end else if (hold_full) begin
                        take  = 1'b1;
                        fresh = align_lo(hold_data, len);
                    end else begin
                        fresh    = fill;
                        ser_d.ur = 1'b1;
                    end
                    ser_d.last = fresh;
                end
                ser_d.sh = fresh;
            end
        end
        if (!tx_en) ser_d.ws_last = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser_q         <= '0;
            ser_q.ws_last <= 1'b1;
        end else begin
            ser_q <= ser_d;
        end
    end

    assign tx_ready    = ~hold_full;
    assign tx_underrun = ser_q.ur;
    assign sd_o        = ser_q.sd;
    assign rx_sd_o     = cfg_loop ? ser_q.sd : rx_sd_i;

endmodule

// File: rtl/i2stx_checker.sv
module i2stx_checker (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic cfg_master,
    input logic wr_valid,
    input logic tx_ready,
    input logic ur_clr,
    input logic tx_underrun,
    input logic bclk_o,
    input logic ws_o,
    input logic sd_o
);
    p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && tx_ready |=> !tx_ready);

    p_ws_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_master && $past(cfg_master) && tx_en && $past(tx_en) && !$stable(ws_o)
        |-> $fell(bclk_o));

    p_sd_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_master && $past(cfg_master) && !$stable(sd_o) |-> $fell(bclk_o));

    p_ur_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_underrun && !ur_clr |=> tx_underrun);

    p_slave_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_master |=> !bclk_o && ws_o);

    p_hold_kept_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en && !tx_ready |=> !tx_ready);

endmodule

bind i2s_tx_serializer i2stx_checker i_chk (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .cfg_master(cfg_master),
    .wr_valid(wr_valid), .tx_ready(tx_ready), .ur_clr(ur_clr),
    .tx_underrun(tx_underrun), .bclk_o(bclk_o), .ws_o(ws_o), .sd_o(sd_o)
);

// File: tb/test_i2s_tx_serializer.sv
module test_i2s_tx_serializer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_en = 1'b0;
    logic        cfg_master = 1'b1;
    logic [2:0]  cfg_len = 3'd0;
    logic        cfg_narrow = 1'b0;
    logic        cfg_mono = 1'b0;
    logic        cfg_repeat = 1'b0;
    logic        cfg_loop = 1'b0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic        ur_clr = 1'b0;
    logic        ext_bclk = 1'b0;
    logic        ext_ws = 1'b1;
    logic        rx_sd_i = 1'b0;
    logic        tx_ready, tx_underrun, bclk_o, ws_o, sd_o, rx_sd_o;

    int errs = 0;
    int checks = 0;
    logic slave_run = 1'b0;

    logic [31:0] fq [16];
    int fq_wr = 0;
    int fq_rd = 0;

    logic [31:0] rec_val [64];
    int          rec_n [64];
    logic        rec_ch [64];
    int          rec_cnt = 0;

    always #5 clk = ~clk;

    i2s_tx_serializer i_i2s_tx_serializer (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .cfg_master(cfg_master),
        .cfg_len(cfg_len), .cfg_narrow(cfg_narrow), .cfg_mono(cfg_mono),
        .cfg_repeat(cfg_repeat), .cfg_loop(cfg_loop), .wr_valid(wr_valid),
        .wr_data(wr_data), .tx_ready(tx_ready), .ur_clr(ur_clr),
        .tx_underrun(tx_underrun), .ext_bclk(ext_bclk), .ext_ws(ext_ws),
        .bclk_o(bclk_o), .ws_o(ws_o), .sd_o(sd_o), .rx_sd_i(rx_sd_i),
        .rx_sd_o(rx_sd_o)
    );

    // feeder: hands queued words to the holding register whenever it is empty
    initial begin
        forever begin
            @(negedge clk);
            wr_valid = 1'b0;
            if (!rst_n) begin
                fq_rd = 0;
            end else if (fq_rd < fq_wr && tx_ready) begin
                wr_data  = fq[fq_rd];
                wr_valid = 1'b1;
                fq_rd++;
            end
        end
    end

    // external clock source for slave mode: 8 clk per half bit, 32-bit slots
    initial begin
        int sc;
        sc = 0;
        forever begin
            if (!slave_run) begin
                ext_bclk = 1'b0;
                ext_ws   = 1'b1;
                sc       = 0;
                @(negedge clk);
            end else begin
                repeat (8) @(negedge clk);
                ext_bclk = 1'b1;
                repeat (8) @(negedge clk);
                ext_bclk = 1'b0;
                sc++;
                if (sc == 32) begin
                    sc     = 0;
                    ext_ws = ~ext_ws;
                end
            end
        end
    end

    // receiver model: samples data on bit clock rising edges
    initial begin
        logic        pb, mws, b, w, d;
        int          mcnt;
        logic [31:0] mcur;
        pb = 1'b0; mws = 1'b1; mcnt = 0; mcur = '0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                rec_cnt = 0; mcnt = 0; mcur = '0; mws = 1'b1; pb = 1'b0;
            end else begin
                b = cfg_master ? bclk_o : ext_bclk;
                if (b && !pb) begin
                    w = cfg_master ? ws_o : ext_ws;
                    d = sd_o;
                    if (mcnt < 32) mcur[31-mcnt] = d;
                    if (w != mws) begin
                        if (rec_cnt < 64) begin
                            rec_val[rec_cnt] = mcur;
                            rec_n[rec_cnt]   = mcnt + 1;
                            rec_ch[rec_cnt]  = mws;
                        end
                        rec_cnt++;
                        mcur = '0;
                        mcnt = 0;
                        mws  = w;
                    end else begin
                        mcnt++;
                    end
                end
                pb = b;
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: run did not complete (actual=hung expected=done)");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] w);
        fq[fq_wr] = w;
        fq_wr++;
    endtask

    task automatic do_reset(input logic m, input logic [2:0] l, input logic nar,
                            input logic mono, input logic rep);
        tx_en = 1'b0; slave_run = 1'b0; ur_clr = 1'b0;
        cfg_master = m; cfg_len = l; cfg_narrow = nar;
        cfg_mono = mono; cfg_repeat = rep; cfg_loop = 1'b0;
        rst_n = 1'b0;
        fq_wr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic start();
        repeat (6) @(negedge clk);
        tx_en = 1'b1;
        if (!cfg_master) slave_run = 1'b1;
    endtask

    task automatic wait_rec(input int n);
        int t;
        t = 0;
        while (rec_cnt < n && t < 30000) begin
            @(negedge clk);
            t++;
        end
    endtask

    task automatic t_reset();
        do_reset(1'b1, 3'd0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        check("R1 ready", {31'b0, tx_ready}, 32'd1);
        check("R1 underrun", {31'b0, tx_underrun}, 32'd0);
        check("R1 sd", {31'b0, sd_o}, 32'd0);
        check("R1 bclk", {31'b0, bclk_o}, 32'd0);
        check("R1 ws", {31'b0, ws_o}, 32'd1);
    endtask

    task automatic t_basic32();
        do_reset(1'b1, 3'd0, 1'b0, 1'b0, 1'b0);
        push(32'h8123_4567); push(32'h7654_3211); push(32'hA5A5_0F0F); push(32'h0000_0001);
        start();
        wait_rec(3);
        check("R8 no underrun while fed", {31'b0, tx_underrun}, 32'd0);
        wait_rec(5);
        check("R3 left word", rec_val[1], 32'h8123_4567);
        check("R3 left channel ws low", {31'b0, rec_ch[1]}, 32'd0);
        check("R3 right word", rec_val[2], 32'h7654_3211);
        check("R3 right channel ws high", {31'b0, rec_ch[2]}, 32'd1);
        check("R4 lsb-only word", rec_val[4], 32'h0000_0001);
        check("R5 32-bit slot", rec_n[1], 32'd32);
    endtask

    task automatic t_ready();
        do_reset(1'b1, 3'd0, 1'b0, 1'b0, 1'b0);
        push(32'h1111_2222);
        repeat (4) @(negedge clk);
        check("R2 ready low when held", {31'b0, tx_ready}, 32'd0);
        check("R13 bclk idle while disabled", {31'b0, bclk_o}, 32'd0);
        repeat (300) @(negedge clk);
        check("R13 word kept while disabled", {31'b0, tx_ready}, 32'd0);
        check("R13 no underrun while disabled", {31'b0, tx_underrun}, 32'd0);
        tx_en = 1'b1;
        wait_rec(2);
        check("R2 ready after load", {31'b0, tx_ready}, 32'd1);
        check("R13 first word in first left slot", rec_val[1], 32'h1111_2222);
    endtask

    task automatic t_lengths();
        do_reset(1'b1, 3'd3, 1'b1, 1'b0, 1'b0);
        push(32'hFFF2_AAAB); push(32'h0001_0001);
        start(); wait_rec(3);
        check("R4 18-bit aligned", rec_val[1], {18'h2AAAB, 14'b0});
        check("R5 narrow slot 24", rec_n[1], 32'd24);
        check("R4 18-bit right", rec_val[2], {18'h10001, 14'b0});

        do_reset(1'b1, 3'd2, 1'b0, 1'b0, 1'b0);
        push(32'hFFF1_2345); push(32'h0);
        start(); wait_rec(3);
        check("R4 20-bit aligned", rec_val[1], 32'h1234_5000);
        check("R5 wide slot 32 for 20-bit", rec_n[1], 32'd32);

        do_reset(1'b1, 3'd4, 1'b0, 1'b0, 1'b0);
        push(32'hFFFF_ABCD); push(32'h1234_8001);
        start(); wait_rec(3);
        check("R4 16-bit upper bits ignored", rec_val[1], 32'hABCD_0000);
        check("R4 16-bit right", rec_val[2], 32'h8001_0000);
        check("R5 16-bit slot", rec_n[1], 32'd16);

        do_reset(1'b1, 3'd6, 1'b0, 1'b0, 1'b0);
        push(32'hFFFF_FF96); push(32'h0000_0069);
        start(); wait_rec(3);
        check("R4 8-bit aligned", rec_val[1], 32'h9600_0000);
        check("R5 8-bit slot", rec_n[2], 32'd8);
    endtask

    task automatic t_mono();
        do_reset(1'b1, 3'd0, 1'b0, 1'b1, 1'b0);
        push(32'hDEAD_BEEF); push(32'h0BAD_F00D);
        start(); wait_rec(5);
        check("R6 left", rec_val[1], 32'hDEAD_BEEF);
        check("R6 right duplicated", rec_val[2], 32'hDEAD_BEEF);
        check("R6 next word in next left", rec_val[3], 32'h0BAD_F00D);
        check("R6 next right duplicated", rec_val[4], 32'h0BAD_F00D);
    endtask

    task automatic t_packed();
        do_reset(1'b1, 3'd5, 1'b0, 1'b0, 1'b0);
        push(32'h1357_2468); push(32'hFFFF_0001);
        start(); wait_rec(5);
        check("R7 packed16 left", rec_val[1], 32'h2468_0000);
        check("R7 packed16 right", rec_val[2], 32'h1357_0000);
        check("R7 packed16 second frame right", rec_val[4], 32'hFFFF_0000);

        do_reset(1'b1, 3'd7, 1'b0, 1'b0, 1'b0);
        push(32'h0000_C3A5);
        start(); wait_rec(3);
        check("R7 packed8 left", rec_val[1], 32'hA500_0000);
        check("R7 packed8 right", rec_val[2], 32'hC300_0000);
    endtask

    task automatic t_underrun_zero();
        do_reset(1'b1, 3'd0, 1'b0, 1'b0, 1'b0);
        push(32'hCAFE_0001); push(32'hCAFE_0002);
        start(); wait_rec(5);
        check("R8 zero-fill left", rec_val[3], 32'h0);
        check("R8 zero-fill right", rec_val[4], 32'h0);
        check("R8 flag raised", {31'b0, tx_underrun}, 32'd1);
        repeat (20) @(negedge clk);
        check("R10 flag sticky", {31'b0, tx_underrun}, 32'd1);
        ur_clr = 1'b1;
        @(negedge clk);
        ur_clr = 1'b0;
        check("R10 flag cleared", {31'b0, tx_underrun}, 32'd0);
    endtask

    task automatic t_underrun_repeat();
        do_reset(1'b1, 3'd4, 1'b0, 1'b0, 1'b1);
        push(32'h0000_1234); push(32'h0000_5678);
        start(); wait_rec(5);
        check("R9 repeat previous in left", rec_val[3], 32'h5678_0000);
        check("R9 repeat previous in right", rec_val[4], 32'h5678_0000);
        check("R9 flag raised", {31'b0, tx_underrun}, 32'd1);
    endtask

    task automatic t_loop();
        int bad;
        do_reset(1'b1, 3'd0, 1'b0, 1'b0, 1'b0);
        push(32'hF0F0_3C3C); push(32'h55AA_33CC);
        cfg_loop = 1'b1;
        start();
        bad = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            rx_sd_i = i[3];
            if (rx_sd_o !== sd_o) bad++;
        end
        check("R11 loopback follows sd_o", bad, 32'd0);
        cfg_loop = 1'b0;
        bad = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            rx_sd_i = i[2];
            #1;
            if (rx_sd_o !== rx_sd_i) bad++;
        end
        check("R11 no loop follows rx_sd_i", bad, 32'd0);
    endtask

    task automatic t_slave();
        do_reset(1'b0, 3'd0, 1'b0, 1'b0, 1'b0);
        push(32'h9ABC_DEF1); push(32'h0FED_CBA8);
        start(); wait_rec(3);
        check("R12 slave left", rec_val[1], 32'h9ABC_DEF1);
        check("R12 slave right", rec_val[2], 32'h0FED_CBA8);
        check("R12 slave slot length", rec_n[1], 32'd32);
        check("R12 bclk_o quiet", {31'b0, bclk_o}, 32'd0);
        check("R12 ws_o quiet", {31'b0, ws_o}, 32'd1);
    endtask

    initial begin
        t_reset();
        t_basic32();
        t_ready();
        t_lengths();
        t_mono();
        t_packed();
        t_underrun_zero();
        t_underrun_repeat();
        t_loop();
        t_slave();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule